// File: doc/BRIEF.md
# Three-Stage Fetch-Decode-Execute Pipeline

This block is a small in-order instruction pipeline with three stages: fetch, decode and execute. An instruction cycle is four clock phases, and each stage holds an instruction for exactly one instruction cycle. It runs a compact eight-opcode instruction set of 16-bit words. All opcodes are one word except a long-address load, which takes two words. Instructions are read from a program-memory port. Loaded data comes from one of three sources: a data port, an external-memory port or an internal read-only array.

Operand addresses are formed in decode. The choice of data source is also made in decode. The condition flags and the mode register are written only at the end of execute. As a result, a write to the mode register that changes the memory map does not affect a load directly behind it. One NOP between the two is enough for the load to see the new map. This one-slot hazard is deliberate and has no interlock. A write to the flags, by contrast, is seen by a conditional jump directly behind it. A taken jump squashes the two younger instructions. Debug outputs show stage occupancy and the architectural registers.

Top module: `tri_stage_core`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, the program counter, mode register, flags and accumulator read zero and all three stage-occupancy outputs are 0.
- R2: The first clock edge after reset release starts the first fetch slot. Each stage lasts four clocks. The effects of the first instruction appear after the 12th clock edge from that point and not after the 11th.
- R3: One-word instructions placed back to back complete one per instruction cycle, each four clocks after the previous one.
- R4: Opcode 7 (long load) is two words, and its second word is the full data address. Its load completes four instruction cycles after it enters fetch. The next word of the program is fetched two cycles after the long load was fetched.
- R5: An address whose upper bits match the window at 0x40..0x4F reads the internal array when mode bit 0 is set; the array word at address a is 0xC300 | a. When mode bit 0 is clear, such an address reads the external port. Any address outside the window reads the data port. Other mode bits have no effect on the map.
- R6: The data address and the source choice are fixed while the load is in decode. A mode write directly ahead of a load therefore leaves that load on the old map. One intervening NOP makes the load use the new map.
- R7: Opcode 2 ORs imm[3:0] into the flags and opcode 3 ANDs imm[3:0] into the flags, both at the end of execute. A conditional jump directly behind either one tests the updated flags, with the same outcome as when four NOPs separate them.
- R8: Opcode 5 is a conditional jump with its mask in bits 11:8, an invert bit in bit 12 and its target in bits 7:0. It is taken when the OR of (flags & mask), XORed with the invert bit, is 1. When taken, the instructions in fetch and decode are discarded, and fetch restarts at the target in the next slot. When not taken, the program falls through.
- R9: Opcode 1 ORs imm[7:0] into the mode register and opcode 6 ANDs imm[7:0] into it, both at the end of execute. Opcode 0 is a NOP. Opcode 4 loads the word at address imm[7:0] into the accumulator. The opcode is bits 15:13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_addr | output | AW | Program-memory read address (fetch PC) |
| pm_data | input | DW | Program word at pm_addr |
| dm_addr | output | AW | Data-port read address |
| dm_data | input | DW | Data-port read word |
| xm_addr | output | AW | External-memory read address |
| xm_data | input | DW | External-memory read word |
| dbg_fetch_v | output | 1 | Fetch stage occupied |
| dbg_dec_v | output | 1 | Decode stage occupied |
| dbg_exe_v | output | 1 | Execute stage occupied |
| dbg_pc | output | AW | Fetch program counter |
| dbg_acc | output | DW | Accumulator |
| dbg_ccr | output | 4 | Condition flags |
| dbg_mode | output | 8 | Mode register |

## Verification
The hardest situation to reach from the ports is the one slot in which a mode write is in execute while a windowed load is in decode. That slot is the only point where the decode-time map choice and the execute-time mode update diverge. The bench places the mode write and the load with zero, one and four NOPs between them. It then compares the accumulator values and expects only the zero-gap run to read the external port. The flag-write-then-jump sequence is run in the same two spacings, and the bench expects identical results from both.

// File: rtl/tri_stage_core.sv
module tri_stage_core #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] WIN_BASE = 8'h40,
  parameter int WIN_LG = 4,
  parameter int MAP_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] pm_addr,
  input  logic [DW-1:0] pm_data,
  output logic [AW-1:0] dm_addr,
  input  logic [DW-1:0] dm_data,
  output logic [AW-1:0] xm_addr,
  input  logic [DW-1:0] xm_data,
  output logic          dbg_fetch_v,
  output logic          dbg_dec_v,
  output logic          dbg_exe_v,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_acc,
  output logic [3:0]    dbg_ccr,
  output logic [7:0]    dbg_mode
);
  localparam logic [2:0] OP_NOP = 3'd0, OP_ORM = 3'd1, OP_ORC = 3'd2, OP_ANDC = 3'd3,
                         OP_LD = 3'd4, OP_JCC = 3'd5, OP_ANDM = 3'd6, OP_LDL = 3'd7;
  localparam logic [1:0] SRC_DM = 2'd0, SRC_XM = 2'd1, SRC_ROM = 2'd2;
  localparam logic [DW-1:0] ROM_TAG = DW'(8'hC3) << AW;

  logic          run;
  logic [1:0]    phase;
  logic [AW-1:0] pc;
  logic          d_v, d_second;
  logic [DW-1:0] d_ir;
  logic          e_v, e_inv;
  logic [2:0]    e_op;
  logic [7:0]    e_imm;
  logic [3:0]    e_mask;
  logic [AW-1:0] e_addr;
  logic [1:0]    e_src;
  logic [7:0]    mode;
  logic [3:0]    ccr;
  logic [DW-1:0] acc;

  wire adv = run && (phase == 2'd3);

  wire [2:0]    d_op   = d_ir[DW-1 -: 3];
  wire [AW-1:0] d_addr = d_ir[AW-1:0];
  wire          in_win = (d_addr >> WIN_LG) == (WIN_BASE >> WIN_LG);
  wire [1:0]    d_src  = !in_win ? SRC_DM : (mode[MAP_BIT] ? SRC_ROM : SRC_XM);
  wire [2:0]    dec_op = !d_v ? OP_NOP : d_second ? OP_LD : (d_op == OP_LDL ? OP_NOP : d_op);

  wire taken = e_v && (e_op == OP_JCC) && ((|(ccr & e_mask)) ^ e_inv);

  logic [DW-1:0] rd_data;
  always_comb begin
    case (e_src)
      SRC_XM:  rd_data = xm_data;
      SRC_ROM: rd_data = ROM_TAG | {{(DW-AW){1'b0}}, e_addr};
      default: rd_data = dm_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;  phase <= 2'd0;  pc <= '0;
      d_v <= 1'b0;  d_second <= 1'b0;  d_ir <= '0;
      e_v <= 1'b0;  e_inv <= 1'b0;  e_op <= OP_NOP;  e_imm <= '0;
      e_mask <= '0;  e_addr <= '0;  e_src <= SRC_DM;
      mode <= '0;  ccr <= '0;  acc <= '0;
    end else begin
      run <= 1'b1;
      if (run) phase <= phase + 2'd1;
      if (adv) begin
        if (e_v) begin
          case (e_op)
            OP_ORM:  mode <= mode | e_imm;
            OP_ANDM: mode <= mode & e_imm;
            OP_ORC:  ccr  <= ccr | e_imm[3:0];
            OP_ANDC: ccr  <= ccr & e_imm[3:0];
            OP_LD:   acc  <= rd_data;
            default: ;
          endcase
        end
        if (taken) begin
          pc <= e_addr;
          d_v <= 1'b0;  d_second <= 1'b0;
          e_v <= 1'b0;  e_op <= OP_NOP;
        end else begin
          pc <= pc + 1'b1;
          d_ir <= pm_data;
          d_v <= 1'b1;
          d_second <= d_v && !d_second && (d_op == OP_LDL);
          e_v <= d_v;
          e_op <= dec_op;
          e_inv <= d_ir[12];
          e_mask <= d_ir[11:8];
          e_imm <= d_ir[7:0];
          e_addr <= d_addr;
          e_src <= d_src;
        end
      end
    end
  end

  assign pm_addr     = pc;
  assign dm_addr     = e_addr;
  assign xm_addr     = e_addr;
  assign dbg_fetch_v = run;
  assign dbg_dec_v   = d_v;
  assign dbg_exe_v   = e_v;
  assign dbg_pc      = pc;
  assign dbg_acc     = acc;
  assign dbg_ccr     = ccr;
  assign dbg_mode    = mode;
endmodule

module tri_stage_core_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [1:0]    phase,
  input logic [AW-1:0] pc,
  input logic [7:0]    mode,
  input logic [3:0]    ccr,
  input logic          d_v,
  input logic          d_second,
  input logic [DW-1:0] d_ir,
  input logic          e_v,
  input logic [2:0]    e_op,
  input logic [AW-1:0] e_addr,
  input logic          taken
);
  wire slot_end = run && (phase == 2'd3);

  p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> ($stable(pc) && $stable(d_v) && $stable(e_v)));

  p_two_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !taken && d_v && !d_second && d_ir[DW-1 -: 3] == 3'd7)
      |=> (d_second && e_v && e_op == 3'd0));

  p_mode_in_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_end && e_v && (e_op == 3'd1 || e_op == 3'd6)) |=> $stable(mode));

  p_ccr_in_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_end && e_v && (e_op == 3'd2 || e_op == 3'd3)) |=> $stable(ccr));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && taken) |=> (!d_v && !e_v && pc == $past(e_addr)));
endmodule

bind tri_stage_core tri_stage_core_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .pc(pc), .mode(mode),
  .ccr(ccr), .d_v(d_v), .d_second(d_second), .d_ir(d_ir), .e_v(e_v),
  .e_op(e_op), .e_addr(e_addr), .taken(taken)
);

// File: tb/tri_stage_core_tb_top.sv
module tri_stage_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  pm_addr, dm_addr, xm_addr;
  logic [15:0] pm_data, dm_data, xm_data;
  logic        fv, dv, ev;
  logic [7:0]  pc, mode;
  logic [15:0] acc;
  logic [3:0]  ccr;
  logic [15:0] pm [256];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign pm_data = pm[pm_addr];
  assign dm_data = 16'hD000 | {8'h00, dm_addr};
  assign xm_data = 16'hE000 | {8'h00, xm_addr};

  tri_stage_core dut_i (
    .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_data(pm_data),
    .dm_addr(dm_addr), .dm_data(dm_data), .xm_addr(xm_addr), .xm_data(xm_data),
    .dbg_fetch_v(fv), .dbg_dec_v(dv), .dbg_exe_v(ev), .dbg_pc(pc),
    .dbg_acc(acc), .dbg_ccr(ccr), .dbg_mode(mode)
  );

  function automatic logic [15:0] w(input logic [2:0] op, input logic [4:0] cf, input logic [7:0] imm);
    return {op, cf, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) pm[i] = 16'h0000;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic boot();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_and_fill();
    clear_prog();
    pm[0] = w(3'd1, 5'd0, 8'h01);
    boot();
    check("R1 occupancy", {fv, dv, ev}, 3'b000);
    check("R1 pc", pc, 0);
    check("R1 mode", mode, 0);
    check("R1 ccr", ccr, 0);
    check("R1 acc", acc, 0);
    step(12);
    check("R2 before 12th edge", mode, 8'h00);
    step(1);
    check("R2 at 12th edge", mode, 8'h01);
  endtask

  task automatic t_throughput();
    clear_prog();
    pm[0] = w(3'd2, 5'd0, 8'h01);
    pm[1] = w(3'd2, 5'd0, 8'h02);
    pm[2] = w(3'd2, 5'd0, 8'h04);
    boot();
    step(13);
    check("R3 first", ccr, 4'h1);
    step(4);
    check("R3 second", ccr, 4'h3);
    step(4);
    check("R3 third", ccr, 4'h7);
  endtask

  task automatic t_two_word();
    clear_prog();
    pm[0] = w(3'd7, 5'd0, 8'h00);
    pm[1] = 16'h0045;
    pm[2] = w(3'd2, 5'd0, 8'h01);
    boot();
    step(16);
    check("R4 load not yet", acc, 16'h0000);
    step(1);
    check("R4 load after four slots", acc, 16'hE045);
    step(3);
    check("R4 next not yet", ccr, 4'h0);
    step(1);
    check("R4 next two slots later", ccr, 4'h1);
  endtask

  task automatic run_ld(input logic [7:0] mset, input int gap, input logic [7:0] addr, output logic [15:0] res);
    clear_prog();
    pm[0] = w(3'd1, 5'd0, mset);
    pm[1 + gap] = w(3'd4, 5'd0, addr);
    boot();
    step(60);
    res = acc;
  endtask

  task automatic t_map();
    logic [15:0] r;
    run_ld(8'h01, 4, 8'h40, r); check("R5 window low set", r, 16'hC340);
    run_ld(8'h01, 4, 8'h4F, r); check("R5 window high set", r, 16'hC34F);
    run_ld(8'h01, 4, 8'h50, r); check("R5 above window", r, 16'hD050);
    run_ld(8'h01, 4, 8'h3F, r); check("R5 below window", r, 16'hD03F);
    run_ld(8'h00, 4, 8'h45, r); check("R5 window clear", r, 16'hE045);
    run_ld(8'h02, 4, 8'h45, r); check("R5 other mode bit", r, 16'hE045);
  endtask

  task automatic t_mode_hazard();
    logic [15:0] r0, r1, r4;
    run_ld(8'h01, 0, 8'h45, r0); check("R6 back to back old map", r0, 16'hE045);
    run_ld(8'h01, 1, 8'h45, r1); check("R6 one NOP new map", r1, 16'hC345);
    run_ld(8'h01, 4, 8'h45, r4); check("R6 four NOPs new map", r4, 16'hC345);
    check("R6 spacing changes result", (r0 != r4), 1);
  endtask

  task automatic run_jump(input logic [15:0] pre, input logic [15:0] pre2, input int gap,
                          input logic [4:0] cf, output logic [7:0] m, output logic [3:0] c);
    clear_prog();
    pm[0] = pre;
    pm[1] = pre2;
    pm[2 + gap] = w(3'd5, cf, 8'h20);
    pm[3 + gap] = w(3'd1, 5'd0, 8'h80);
    pm[4 + gap] = w(3'd1, 5'd0, 8'h40);
    pm[8'h20]   = w(3'd1, 5'd0, 8'h10);
    boot();
    step(180);
    m = mode;
    c = ccr;
  endtask

  task automatic t_flags_jump();
    logic [7:0] m0, m4;
    logic [3:0] c0, c4;
    run_jump(w(3'd2, 5'd0, 8'h01), 16'h0000, 0, 5'h01, m0, c0);
    check("R7 ORC then jump taken", m0, 8'h10);
    check("R8 flushed younger", m0 & 8'hC0, 8'h00);
    run_jump(w(3'd2, 5'd0, 8'h01), 16'h0000, 4, 5'h01, m4, c4);
    check("R7 same as spaced", {m0, c0}, {m4, c4});
    run_jump(w(3'd2, 5'd0, 8'h03), w(3'd3, 5'd0, 8'h0E), 0, 5'h01, m0, c0);
    check("R7 ANDC then jump falls through", m0, 8'hD0);
    check("R7 ANDC flags", c0, 4'h2);
    run_jump(w(3'd2, 5'd0, 8'h03), w(3'd3, 5'd0, 8'h0E), 4, 5'h01, m4, c4);
    check("R7 ANDC same as spaced", {m0, c0}, {m4, c4});
    run_jump(16'h0000, 16'h0000, 0, 5'h11, m0, c0);
    check("R8 inverted condition taken", m0, 8'h10);
    run_jump(16'h0000, 16'h0000, 0, 5'h01, m0, c0);
    check("R8 not taken falls through", m0, 8'hD0);
  endtask

  task automatic t_mode_ops();
    logic [15:0] r;
    clear_prog();
    pm[0] = w(3'd1, 5'd0, 8'h05);
    pm[1] = w(3'd6, 5'd0, 8'hFE);
    pm[3] = w(3'd4, 5'd0, 8'h45);
    boot();
    step(60);
    check("R9 ORM then ANDM", mode, 8'h04);
    check("R9 cleared bit gives external", acc, 16'hE045);
    run_ld(8'h00, 0, 8'h12, r);
    check("R9 plain load", r, 16'hD012);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_and_fill();
    t_throughput();
    t_two_word();
    t_map();
    t_mode_hazard();
    t_flags_jump();
    t_mode_ops();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule